// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside a receive MAC and decides, from the first six bytes of each incoming frame, whether the frame is kept. It is fed the destination address one byte per cycle and checks it in three ways. An individual address must equal the programmed station address. A group address is looked up in a 64-entry hash table whose index is taken from a CRC-32 over the address. The all-ones address is treated as broadcast. Two controls change the result: a promiscuous enable that keeps every frame, and a broadcast drop that discards broadcast frames.

The result is a registered decision. It carries a keep flag, broadcast and multicast indications for the receive status, and a flag that marks frames kept only because promiscuous mode is on. The decision is published in the cycle after the last address byte. It stays unchanged while the rest of the frame streams past, and it is withdrawn when the next frame begins. Station address, hash table and controls are static inputs, sampled when the sixth byte is taken.

Top module: `rx_dest_filter`

## Requirements
- R1: An address starts with a byte presented while `frame_start` and `byte_valid` are both high. The next five bytes are taken on `byte_valid` alone. Bytes presented while no address is being collected are ignored. A new `frame_start` byte in the middle of an address restarts collection from that byte.
- R2: `decision_valid` and the decision outputs become valid in the cycle after the clock edge that samples the sixth address byte. They then hold their values unchanged, whatever later bytes or configuration changes occur, until the edge that samples the next `frame_start` byte. The configuration used is the one present at the edge that samples the sixth byte.
- R3: At the edge that samples a `frame_start` byte, `decision_valid` and all decision outputs go to 0.
- R4: An address whose six bytes are all 0xFF is broadcast. `addr_bcast` is 1 for it and `addr_mcast` is 0.
- R5: An address whose first byte has bit 0 set, and which is not broadcast, is multicast: `addr_mcast` is 1. `addr_bcast` and `addr_mcast` are never 1 together.
- R6: An address with bit 0 of its first byte clear is kept only when it equals the station address. Byte 0 (first received) is `station_lo[31:24]`, byte 1 is `[23:16]`, byte 2 is `[15:8]`, byte 3 is `[7:0]`, byte 4 is `station_hi[31:24]` and byte 5 is `station_hi[23:16]`.
- R7: A multicast address is kept when the table bit at the hash index is 1. The table is `{group_hash_hi, group_hash_lo}`, so bits 0..31 come from `group_hash_lo` and bits 32..63 from `group_hash_hi`. The index is bits 31:26 of a 32-bit register. That register starts at 0xFFFFFFFF and, for each address bit taken least significant bit of each byte first, shifts right by one and is XORed with 0xEDB88320 when its old bit 0 differed from the data bit. No final inversion is applied.
- R8: When `bcast_drop` is 1, a broadcast address is not kept (unless R9 applies). When `bcast_drop` is 0, a broadcast address is kept.
- R9: When `promisc_en` is 1, every address is kept. `promisc_only` is 1 exactly when the frame is kept but would not have been kept with `promisc_en` at 0.
- R10: After reset, and whenever `decision_valid` is 0, all decision outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Marks the first address byte of a frame |
| byte_valid | input | 1 | `byte_data` carries a byte this cycle |
| byte_data | input | 8 | Received byte |
| station_lo | input | 32 | Station address bytes 0..3 |
| station_hi | input | 32 | Station address bytes 4..5 in bits 31:16 |
| group_hash_lo | input | 32 | Hash table bits 31:0 |
| group_hash_hi | input | 32 | Hash table bits 63:32 |
| promisc_en | input | 1 | Keep every frame |
| bcast_drop | input | 1 | Discard broadcast frames |
| decision_valid | output | 1 | Decision outputs are valid |
| frame_accept | output | 1 | Frame is kept |
| addr_bcast | output | 1 | Destination is broadcast |
| addr_mcast | output | 1 | Destination is multicast |
| promisc_only | output | 1 | Kept only because of promiscuous mode |

## Verification
A wrong byte counter moves the rising edge of `decision_valid` by whole cycles, or leaves it stuck low. The bench therefore checks `decision_valid` both at the sixth byte and one cycle after it. A corrupted CRC register or match flag shows only in `frame_accept`, so the bench computes the hash index itself and sets either exactly the indexed table bit or every other bit. This is done for indexes in both table halves. Hold and restart faults appear one cycle after the offending byte, and the bench probes for them by streaming payload bytes, changing the configuration and restarting a frame partway through its address.

// File: rtl/rdf_pkg.sv
package rdf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;
    localparam int HASH_IDX_W = 6;
    localparam int HASH_BITS  = 1 << HASH_IDX_W;
    localparam int REG_W      = 32;
    localparam int IDX_W      = $clog2(ADDR_BYTES);

    typedef enum logic [0:0] {
        TRK_IDLE    = 1'b0,
        TRK_COLLECT = 1'b1
    } trk_state_t;

    // Running classification of the address seen so far.
    typedef struct packed {
        logic all_ones;
        logic group_bit;
        logic station_eq;
    } addr_class_t;

    // Registered decision.
    typedef struct packed {
        logic valid;
        logic accept;
        logic bcast;
        logic mcast;
        logic miss;
    } decision_t;

    // One byte of reflected CRC-32, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0] crc_in,
        input logic [7:0]       data
    );
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ data[i])
                c = (c >> 1) ^ CRC_POLY;
            else
                c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic [HASH_IDX_W-1:0] hash_index(
        input logic [CRC_W-1:0] crc
    );
        return crc[CRC_W-1 -: HASH_IDX_W];
    endfunction

    // Station byte n, byte 0 in the top of the lower register.
    function automatic logic [7:0] station_byte(
        input logic [REG_W-1:0] lo,
        input logic [REG_W-1:0] hi,
        input logic [IDX_W-1:0] idx
    );
        logic [2*REG_W-1:0] flat;
        flat = {lo, hi};
        return flat[2*REG_W-1 - 8*int'(idx) -: 8];
    endfunction

endpackage

// File: rtl/rdf_crc_acc.sv
module rdf_crc_acc
    import rdf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             step,
    input  logic [7:0]       data,
    output logic [CRC_W-1:0] crc_next
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] base;

    always_comb begin
        base     = restart ? CRC_SEED : crc_q;
        crc_next = crc_step_byte(base, data);
    end

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= CRC_SEED;
        else if (step)
            crc_q <= crc_next;
    end
endmodule

// File: rtl/rdf_addr_track.sv
module rdf_addr_track
    import rdf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic [REG_W-1:0] station_lo,
    input  logic [REG_W-1:0] station_hi,
    output logic             take_first,
    output logic             take_byte,
    output logic             last_byte,
    output addr_class_t      cls_next
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

    trk_state_t       state_q;
    logic [IDX_W-1:0] count_q;
    addr_class_t      cls_q;
    logic [IDX_W-1:0] cur_idx;
    logic             byte_eq;
    logic             byte_ones;
    logic             take_next;

    always_comb begin
        take_first = byte_valid && frame_start;
        take_next  = byte_valid && !frame_start && (state_q == TRK_COLLECT);
        take_byte  = take_first || take_next;
        last_byte  = take_next && (count_q == LAST_IDX);
        cur_idx    = take_first ? '0 : count_q;
        byte_eq    = (byte_data == station_byte(station_lo, station_hi, cur_idx));
        byte_ones  = (byte_data == 8'hFF);
        if (take_first) begin
            cls_next.all_ones   = byte_ones;
            cls_next.group_bit  = byte_data[0];
            cls_next.station_eq = byte_eq;
        end else begin
            cls_next.all_ones   = cls_q.all_ones && byte_ones;
            cls_next.group_bit  = cls_q.group_bit;
            cls_next.station_eq = cls_q.station_eq && byte_eq;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRK_IDLE;
            count_q <= '0;
            cls_q   <= '0;
        end else if (take_first) begin
            state_q <= TRK_COLLECT;
            count_q <= IDX_W'(1);
            cls_q   <= cls_next;
        end else if (take_next) begin
            cls_q <= cls_next;
            if (last_byte) begin
                state_q <= TRK_IDLE;
                count_q <= '0;
            end else begin
                count_q <= count_q + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/rdf_hash_lookup.sv
module rdf_hash_lookup
    import rdf_pkg::*;
(
    input  logic [CRC_W-1:0] crc,
    input  logic [REG_W-1:0] table_lo,
    input  logic [REG_W-1:0] table_hi,
    output logic             hit
);
    localparam int REGS = HASH_BITS / REG_W;

    logic [HASH_BITS-1:0]  table_flat;
    logic [HASH_IDX_W-1:0] idx;

    generate
        if (REGS == 2) begin : g_two_regs
            assign table_flat = {table_hi, table_lo};
        end else begin : g_one_reg
            assign table_flat = HASH_BITS'({table_hi, table_lo});
        end
    endgenerate

    always_comb begin
        idx = hash_index(crc);
        hit = table_flat[idx];
    end
endmodule

// File: rtl/rdf_decide.sv
module rdf_decide
    import rdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        load,
    input  addr_class_t cls,
    input  logic        hash_hit,
    input  logic        promisc_en,
    input  logic        bcast_drop,
    output decision_t   dec
);
    logic      is_bcast;
    logic      is_mcast;
    logic      normal_keep;
    decision_t dec_d;

    always_comb begin
        is_bcast = cls.all_ones;
        is_mcast = cls.group_bit && !cls.all_ones;
        if (is_bcast)
            normal_keep = !bcast_drop;
        else if (is_mcast)
            normal_keep = hash_hit;
        else
            normal_keep = cls.station_eq;
        dec_d.valid  = 1'b1;
        dec_d.accept = promisc_en || normal_keep;
        dec_d.bcast  = is_bcast;
        dec_d.mcast  = is_mcast;
        dec_d.miss   = promisc_en && !normal_keep;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            dec <= '0;
        else if (load)
            dec <= dec_d;
    end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic [31:0] station_lo,
    input  logic [31:0] station_hi,
    input  logic [31:0] group_hash_lo,
    input  logic [31:0] group_hash_hi,
    input  logic        promisc_en,
    input  logic        bcast_drop,
    output logic        decision_valid,
    output logic        frame_accept,
    output logic        addr_bcast,
    output logic        addr_mcast,
    output logic        promisc_only
);
    logic             take_first;
    logic             take_byte;
    logic             last_byte;
    addr_class_t      cls_next;
    logic [CRC_W-1:0] crc_next;
    logic             hash_hit;
    decision_t        dec;

    rdf_addr_track u_track (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .station_lo (station_lo),
        .station_hi (station_hi),
        .take_first (take_first),
        .take_byte  (take_byte),
        .last_byte  (last_byte),
        .cls_next   (cls_next)
    );

    rdf_crc_acc u_crc (
        .clk     (clk),
        .rst     (rst),
        .restart (take_first),
        .step    (take_byte),
        .data    (byte_data),
        .crc_next(crc_next)
    );

    rdf_hash_lookup u_hash (
        .crc     (crc_next),
        .table_lo(group_hash_lo),
        .table_hi(group_hash_hi),
        .hit     (hash_hit)
    );

    rdf_decide u_decide (
        .clk       (clk),
        .rst       (rst),
        .clear     (take_first),
        .load      (last_byte),
        .cls       (cls_next),
        .hash_hit  (hash_hit),
        .promisc_en(promisc_en),
        .bcast_drop(bcast_drop),
        .dec       (dec)
    );

    assign decision_valid = dec.valid;
    assign frame_accept   = dec.accept;
    assign addr_bcast     = dec.bcast;
    assign addr_mcast     = dec.mcast;
    assign promisc_only   = dec.miss;
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk (
    input logic clk,
    input logic rst,
    input logic frame_start,
    input logic byte_valid,
    input logic decision_valid,
    input logic frame_accept,
    input logic addr_bcast,
    input logic addr_mcast,
    input logic promisc_only
);
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!decision_valid && !frame_accept && !addr_bcast && !addr_mcast && !promisc_only));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !decision_valid |-> (!frame_accept && !addr_bcast && !addr_mcast && !promisc_only));

    assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_start && byte_valid) |=> !decision_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (decision_valid && !(frame_start && byte_valid)) |=>
            (decision_valid && $stable(frame_accept) && $stable(addr_bcast)
             && $stable(addr_mcast) && $stable(promisc_only)));

    assert_rise_on_byte_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(decision_valid) |-> $past(byte_valid && !frame_start));

    assert_class_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(addr_bcast && addr_mcast));

    assert_miss_implies_keep_R9: assert property (@(posedge clk) disable iff (rst)
        promisc_only |-> (frame_accept && decision_valid));
endmodule

bind rx_dest_filter rx_dest_filter_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .frame_start   (frame_start),
    .byte_valid    (byte_valid),
    .decision_valid(decision_valid),
    .frame_accept  (frame_accept),
    .addr_bcast    (addr_bcast),
    .addr_mcast    (addr_mcast),
    .promisc_only  (promisc_only)
);

// File: tb/rx_dest_filter_tb_top.sv
`timescale 1ns/1ps
module rx_dest_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [31:0] station_lo = 32'h02112233;
    logic [31:0] station_hi = 32'h44550000;
    logic [31:0] group_hash_lo = 32'h0;
    logic [31:0] group_hash_hi = 32'h0;
    logic        promisc_en = 1'b0;
    logic        bcast_drop = 1'b0;
    logic        decision_valid, frame_accept, addr_bcast, addr_mcast, promisc_only;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    localparam logic [47:0] STATION = 48'h021122334455;
    localparam logic [47:0] OTHER   = 48'h021122334456;
    localparam logic [47:0] BCAST   = 48'hFFFFFFFFFFFF;
    localparam logic [47:0] MC_A    = 48'h01005E000001;
    localparam logic [47:0] MC_B    = 48'h333300000001;

    always #4 clk = ~clk;

    rx_dest_filter dut_i (
        .clk(clk), .rst(rst), .frame_start(frame_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .station_lo(station_lo), .station_hi(station_hi),
        .group_hash_lo(group_hash_lo), .group_hash_hi(group_hash_hi),
        .promisc_en(promisc_en), .bcast_drop(bcast_drop),
        .decision_valid(decision_valid), .frame_accept(frame_accept),
        .addr_bcast(addr_bcast), .addr_mcast(addr_mcast), .promisc_only(promisc_only)
    );

    // Hash index from the requirement text: bitwise over the 48-bit address.
    function automatic logic [5:0] ref_index(input logic [47:0] a);
        logic [31:0] r = 32'hFFFFFFFF;
        for (int b = 0; b < 6; b++) begin
            for (int k = 0; k < 8; k++) begin
                logic bit_in;
                bit_in = a[47 - 8*b - 7 + k];
                r = (r[0] ^ bit_in) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
            end
        end
        return r[31:26];
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic put_byte(input logic sof, input logic [7:0] d);
        @(negedge clk);
        frame_start = sof;
        byte_valid  = 1'b1;
        byte_data   = d;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        frame_start = 1'b0;
        byte_valid  = 1'b0;
    endtask

    // Send six address bytes; the decision is sampled at the negedge after the last.
    task automatic send_addr(input logic [47:0] a);
        for (int b = 0; b < 6; b++) begin
            put_byte(b == 0, a[47 - 8*b -: 8]);
            if (b >= 1) check("R3", "valid low while collecting", decision_valid, 1'b0);
        end
        idle_cycle();
    endtask

    task automatic expect_dec(input string req, input logic acc, input logic bc,
                              input logic mc, input logic miss);
        check(req, "decision_valid", decision_valid, 1'b1);
        check(req, "frame_accept", frame_accept, acc);
        check(req, "addr_bcast", addr_bcast, bc);
        check(req, "addr_mcast", addr_mcast, mc);
        check(req, "promisc_only", promisc_only, miss);
    endtask

    task automatic t_reset_and_stray();
        check("R10", "reset valid", decision_valid, 1'b0);
        check("R10", "reset accept", frame_accept, 1'b0);
        for (int b = 0; b < 7; b++) put_byte(1'b0, STATION[47 - 8*(b%6) -: 8]);
        idle_cycle();
        check("R1", "bytes without frame_start ignored", decision_valid, 1'b0);
    endtask

    task automatic t_unicast();
        send_addr(STATION);
        expect_dec("R6", 1'b1, 1'b0, 1'b0, 1'b0);
        send_addr(OTHER);
        expect_dec("R6", 1'b0, 1'b0, 1'b0, 1'b0);
        promisc_en = 1'b1;
        send_addr(OTHER);
        expect_dec("R9", 1'b1, 1'b0, 1'b0, 1'b1);
        send_addr(STATION);
        expect_dec("R9", 1'b1, 1'b0, 1'b0, 1'b0);
        promisc_en = 1'b0;
    endtask

    task automatic t_timing();
        // Valid must be low right after the sixth byte is driven, high one cycle later.
        for (int b = 0; b < 6; b++) put_byte(b == 0, STATION[47 - 8*b -: 8]);
        #1;
        check("R2", "not valid before sixth byte sampled", decision_valid, 1'b0);
        idle_cycle();
        check("R2", "valid one cycle after sixth byte", decision_valid, 1'b1);
    endtask

    task automatic t_broadcast();
        send_addr(BCAST);
        expect_dec("R4", 1'b1, 1'b1, 1'b0, 1'b0);
        bcast_drop = 1'b1;
        send_addr(BCAST);
        expect_dec("R8", 1'b0, 1'b1, 1'b0, 1'b0);
        promisc_en = 1'b1;
        send_addr(BCAST);
        expect_dec("R9", 1'b1, 1'b1, 1'b0, 1'b1);
        promisc_en = 1'b0;
        bcast_drop = 1'b0;
    endtask

    task automatic t_multicast(input logic [47:0] a);
        logic [5:0]  idx;
        logic [63:0] tbl;
        idx = ref_index(a);
        tbl = 64'd1 << idx;
        group_hash_lo = tbl[31:0];
        group_hash_hi = tbl[63:32];
        send_addr(a);
        expect_dec("R7", 1'b1, 1'b0, 1'b1, 1'b0);
        tbl = ~tbl;
        group_hash_lo = tbl[31:0];
        group_hash_hi = tbl[63:32];
        send_addr(a);
        expect_dec("R7", 1'b0, 1'b0, 1'b1, 1'b0);
        check("R5", "group bit marks multicast", addr_mcast, 1'b1);
        group_hash_lo = 32'h0;
        group_hash_hi = 32'h0;
    endtask

    task automatic t_hold();
        send_addr(STATION);
        for (int b = 0; b < 5; b++) put_byte(1'b0, 8'hFF);
        station_lo = 32'hDEADBEEF;
        bcast_drop = 1'b1;
        idle_cycle();
        idle_cycle();
        check("R2", "held through payload and config change", frame_accept, 1'b1);
        check("R2", "valid held", decision_valid, 1'b1);
        station_lo = 32'h02112233;
        bcast_drop = 1'b0;
        put_byte(1'b1, 8'h02);
        idle_cycle();
        check("R3", "frame_start clears valid", decision_valid, 1'b0);
        check("R3", "frame_start clears accept", frame_accept, 1'b0);
    endtask

    task automatic t_restart();
        put_byte(1'b1, 8'h02);
        put_byte(1'b0, 8'h99);
        put_byte(1'b0, 8'h98);
        send_addr(STATION);
        expect_dec("R1", 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_and_stray();
        t_timing();
        t_unicast();
        t_broadcast();
        t_multicast(MC_A);
        t_multicast(MC_B);
        t_hold();
        t_restart();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                tests_run++;
                tests_failed++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule